// File: doc/BRIEF.md
# Serial memory command front end

This block is the slave side of a four-wire serial link to a 256-byte memory. The link is an active-low select, a serial clock, a serial data input and a serial data output with its own output enable, which a pad wrapper uses to tri-state the pin. Every selection opens with an 8-bit opcode that the block shifts in and decodes. An array read takes one address byte and then streams memory bytes for as long as the host keeps clocking, moving the address forward one byte at a time. A status read returns a single status byte built from live status inputs.

Commands that change state are not carried out here. These are the write-enable set and clear commands, the status write and the array write. The block decodes them and hands them to a separate controller. It gives the controller a command pulse, every byte that follows the opcode, and an end-of-transfer pulse. That pulse carries a flag telling whether the selection ended on a byte boundary. The controller owns protection, write timing and the array write port, so it can fill the internal synchronous array.

The serial pins are brought into the system clock domain through a synchronizer of configurable depth. Clock edges are then found by comparing successive samples. The serial clock must therefore run well below the system clock.

Top module: `sermem_front`

## Requirements
- R1: After the 8th captured opcode bit, a write-type opcode gives a one-cycle `cmd_valid` with `cmd_kind`. The encoding is 0x06 → 0 (set write enable), 0x04 → 1 (clear write enable), 0x01 → 2 (status write) and 0x02 → 3 (array write). The other opcodes give no pulse.
- R2: Opcode, address and write bytes are captured on the rising serial clock edge, most significant bit first.
- R3: `sdo` only changes value after a falling serial clock edge, while output is enabled.
- R4: Opcode 0x03 followed by an address byte drives the byte stored at that address, MSB first. Its first bit appears on the falling edge after the last address bit.
- R5: After every 8 data bits of an array read, the address advances by one and wraps from 0xFF to 0x00, so clocking continues with consecutive bytes.
- R6: Opcode 0x05 returns the status byte {1,1,1,1,`prot_bits[1]`,`prot_bits[0]`,`wr_latch`,`wr_busy`}. It is sampled at the first falling edge, including while `wr_busy` is 1.
- R7: After the 8th status bit, `sdo_oe` is 0 and further clocks produce no output, command or byte until deselect.
- R8: Any opcode other than 0x01–0x06 makes the block ignore input, with `sdo_oe` at 0, until deselect.
- R9: Raising `sel_n` aborts any transfer and drops `sdo_oe`. It gives one `xfer_end` pulse with `end_whole` = 1 only if the clock count since select was a multiple of 8. The next selection starts with a fresh opcode.
- R10: After opcode 0x01 or 0x02, each further complete byte appears as a one-cycle `rx_valid` with `rx_byte`, while `sdo_oe` stays 0.
- R11: After reset, `sdo_oe`, `cmd_valid`, `rx_valid` and `xfer_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low serial select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| prot_bits | input | 2 | Protection bits reported in the status byte |
| wr_latch | input | 1 | Write-enable latch state for the status byte |
| wr_busy | input | 1 | Write-in-progress flag for the status byte |
| mem_we | input | 1 | Array write strobe from the controller |
| mem_waddr | input | ADDR_W | Array write address |
| mem_wdata | input | 8 | Array write data |
| cmd_valid | output | 1 | Write-type command decoded |
| cmd_kind | output | 2 | Which write-type command |
| rx_valid | output | 1 | A byte following a write-type opcode is ready |
| rx_byte | output | 8 | That byte |
| xfer_end | output | 1 | Selection ended |
| end_whole | output | 1 | Selection ended on a byte boundary |

## Verification
The hardest state to reach from the ports is a selection that ends partway through a byte during an array read. The next selection must then start cleanly at the opcode. The stimulus gets there with a read that is deselected after three data clocks. It then expects `xfer_end` with `end_whole` clear and `sdo_oe` low, and runs a complete read that must return the right byte. The address wrap is reached by starting a multi-byte read at 0xFE. The status wait state is held under extra clocks, to show that nothing is decoded or driven there.

// File: rtl/smcf_pkg.sv
package smcf_pkg;

   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W);

   localparam logic [BYTE_W-1:0] OP_SET_WE  = 8'h06;
   localparam logic [BYTE_W-1:0] OP_CLR_WE  = 8'h04;
   localparam logic [BYTE_W-1:0] OP_RD_STAT = 8'h05;
   localparam logic [BYTE_W-1:0] OP_WR_STAT = 8'h01;
   localparam logic [BYTE_W-1:0] OP_RD_ARR  = 8'h03;
   localparam logic [BYTE_W-1:0] OP_WR_ARR  = 8'h02;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPCODE,
      PH_ADDR,
      PH_ARRAY_OUT,
      PH_STAT_OUT,
      PH_WR_BYTES,
      PH_PARK
   } phase_t;

   typedef enum logic [1:0] {
      CMD_SET_WE  = 2'd0,
      CMD_CLR_WE  = 2'd1,
      CMD_WR_STAT = 2'd2,
      CMD_WR_ARR  = 2'd3
   } wcmd_t;

   function automatic logic [BYTE_W-1:0] status_byte(input logic [1:0] bp,
                                                     input logic       wel,
                                                     input logic       wip);
      return {4'hF, bp, wel, wip};
   endfunction

endpackage

// File: rtl/smcf_pin_sync.sv
// Brings select, clock and data into the system clock domain and
// derives one-cycle serial clock edge strobes.
module smcf_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic sck,
   input  logic sdi,
   output logic sel_act,
   output logic sck_rise,
   output logic sck_fall,
   output logic sdi_s
);

   localparam int         PINS     = 3;
   localparam logic [2:0] PIN_IDLE = 3'b100;

   logic [PINS-1:0] raw;
   logic [PINS-1:0] synced;
   logic            sck_prev;

   assign raw = {sel_n, sck, sdi};

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("smcf_pin_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign synced = raw;
      end else begin : g_chain
         logic [PINS-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= PIN_IDLE;
            end else begin
               st[0] <= raw;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign synced = st[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= synced[1];
   end

   assign sel_act  = ~synced[2];
   assign sck_rise = sel_act &  synced[1] & ~sck_prev;
   assign sck_fall = sel_act & ~synced[1] &  sck_prev;
   assign sdi_s    = synced[0];

endmodule

// File: rtl/smcf_rx_shift.sv
// Counts rising edges and assembles incoming bytes, MSB first.
module smcf_rx_shift
   import smcf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [CNT_W-1:0]  cnt,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (clear) begin
         sh  <= '0;
         cnt <= '0;
      end else if (shift_en) begin
         sh  <= {sh[BYTE_W-2:0], bit_in};
         cnt <= cnt + 1'b1;
      end
   end

   assign byte_done = shift_en & (cnt == LAST);
   assign byte_val  = {sh[BYTE_W-2:0], bit_in};

endmodule

// File: rtl/smcf_tx_shift.sv
// Output shifter: loaded or advanced on falling serial clock edges.
module smcf_tx_shift
   import smcf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [BYTE_W-1:0] din,
   output logic              bit_out
);

   logic [BYTE_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= din;
      else if (shift) sh <= {sh[BYTE_W-2:0], 1'b0};
   end

   assign bit_out = sh[BYTE_W-1];

endmodule

// File: rtl/smcf_ram.sv
// Synchronous byte array, one write port and one registered read port.
module smcf_ram
   import smcf_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      rdata <= cells[raddr];
   end

endmodule

// File: rtl/sermem_front.sv
module sermem_front
   import smcf_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sck,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic [1:0]        prot_bits,
   input  logic              wr_latch,
   input  logic              wr_busy,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_waddr,
   input  logic [7:0]        mem_wdata,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic              rx_valid,
   output logic [7:0]        rx_byte,
   output logic              xfer_end,
   output logic              end_whole
);

   localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr
         $error("sermem_front: ADDR_W must be 1..8 (single address byte)");
      end
   endgenerate

   // pin capture
   logic sel_act, sck_rise, sck_fall, sdi_s;

   smcf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (sel_n),
      .sck     (sck),
      .sdi     (sdi),
      .sel_act (sel_act),
      .sck_rise(sck_rise),
      .sck_fall(sck_fall),
      .sdi_s   (sdi_s)
   );

   // byte assembly
   logic [CNT_W-1:0]  bit_cnt;
   logic              byte_done;
   logic [BYTE_W-1:0] byte_val;

   smcf_rx_shift u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (~sel_act),
      .shift_en (sck_rise),
      .bit_in   (sdi_s),
      .cnt      (bit_cnt),
      .byte_done(byte_done),
      .byte_val (byte_val)
   );

   // state
   phase_t            phase_q;
   logic [ADDR_W-1:0] addr_q;
   logic              drv_q;
   logic              sel_act_q;
   wcmd_t             cmd_kind_q;

   // memory
   logic [BYTE_W-1:0] ram_rdata;

   smcf_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(addr_q),
      .rdata(ram_rdata)
   );

   // opcode decode
   logic   op_cmd;
   logic   op_known;
   wcmd_t  op_kind;
   phase_t op_next;

   always_comb begin
      op_cmd   = 1'b0;
      op_known = 1'b1;
      op_kind  = CMD_SET_WE;
      op_next  = PH_PARK;
      case (byte_val)
         OP_SET_WE:  begin op_cmd = 1'b1; op_kind = CMD_SET_WE; end
         OP_CLR_WE:  begin op_cmd = 1'b1; op_kind = CMD_CLR_WE; end
         OP_RD_STAT: op_next = PH_STAT_OUT;
         OP_WR_STAT: begin op_cmd = 1'b1; op_kind = CMD_WR_STAT; op_next = PH_WR_BYTES; end
         OP_RD_ARR:  op_next = PH_ADDR;
         OP_WR_ARR:  begin op_cmd = 1'b1; op_kind = CMD_WR_ARR; op_next = PH_WR_BYTES; end
         default:    op_known = 1'b0;
      endcase
   end

   // output path
   logic out_phase;
   logic tx_load, tx_shift, tx_bit;
   logic [BYTE_W-1:0] tx_din;

   assign out_phase = (phase_q == PH_ARRAY_OUT) || (phase_q == PH_STAT_OUT);
   assign tx_load   = out_phase & sck_fall & (bit_cnt == '0);
   assign tx_shift  = out_phase & sck_fall & (bit_cnt != '0);
   assign tx_din    = (phase_q == PH_STAT_OUT) ? status_byte(prot_bits, wr_latch, wr_busy)
                                               : ram_rdata;

   smcf_tx_shift u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tx_load),
      .shift  (tx_shift),
      .din    (tx_din),
      .bit_out(tx_bit)
   );

   assign sdo_oe = drv_q & out_phase;
   assign sdo    = sdo_oe & tx_bit;

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         addr_q     <= '0;
         drv_q      <= 1'b0;
         sel_act_q  <= 1'b0;
         cmd_valid  <= 1'b0;
         cmd_kind_q <= CMD_SET_WE;
         rx_valid   <= 1'b0;
         rx_byte    <= '0;
         xfer_end   <= 1'b0;
         end_whole  <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         rx_valid  <= 1'b0;
         xfer_end  <= 1'b0;
         sel_act_q <= sel_act;
         if (!sel_act) begin
            phase_q <= PH_IDLE;
            drv_q   <= 1'b0;
            if (sel_act_q) begin
               xfer_end  <= 1'b1;
               end_whole <= (bit_cnt == '0);
            end
         end else begin
            case (phase_q)
               PH_IDLE: phase_q <= PH_OPCODE;
               PH_OPCODE: if (byte_done) begin
                  phase_q <= op_next;
                  if (op_cmd) begin
                     cmd_valid  <= 1'b1;
                     cmd_kind_q <= op_kind;
                  end
               end
               PH_ADDR: if (byte_done) begin
                  addr_q  <= byte_val[ADDR_W-1:0];
                  phase_q <= PH_ARRAY_OUT;
               end
               PH_ARRAY_OUT: begin
                  if (sck_fall)  drv_q  <= 1'b1;
                  if (byte_done) addr_q <= addr_q + 1'b1;
               end
               PH_STAT_OUT: begin
                  if (sck_fall) drv_q <= 1'b1;
                  if (byte_done) begin
                     phase_q <= PH_PARK;
                     drv_q   <= 1'b0;
                  end
               end
               PH_WR_BYTES: if (byte_done) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= byte_val;
               end
               default: ;
            endcase
         end
      end
   end

   assign cmd_kind = cmd_kind_q;

   // checks guarding the sequencing
   p_cmd_from_opcode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(phase_q) == PH_OPCODE);

   p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe) && sdo != $past(sdo)) |-> $past(sck_fall));

   p_addr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ARRAY_OUT && sel_act && byte_done && addr_q == ADDR_TOP)
      |=> addr_q == '0);

   p_park_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PARK) |-> !sdo_oe);

   p_unknown_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OPCODE && sel_act && byte_done && !op_known)
      |=> (phase_q == PH_PARK || phase_q == PH_IDLE) && !cmd_valid);

   p_desel_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_act |=> !sdo_oe);

   p_rx_only_writes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(phase_q) == PH_WR_BYTES && !sdo_oe);

endmodule

// File: tb/sermem_front_test.sv
module sermem_front_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1;
   logic       sck = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo, sdo_oe;
   logic [1:0] prot_bits = 2'b00;
   logic       wr_latch = 1'b0;
   logic       wr_busy = 1'b0;
   logic       mem_we = 1'b0;
   logic [7:0] mem_waddr = '0;
   logic [7:0] mem_wdata = '0;
   logic       cmd_valid, rx_valid, xfer_end, end_whole;
   logic [1:0] cmd_kind;
   logic [7:0] rx_byte;

   always #2 clk = ~clk;   // 250 MHz

   sermem_front uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .prot_bits(prot_bits), .wr_latch(wr_latch),
      .wr_busy(wr_busy), .mem_we(mem_we), .mem_waddr(mem_waddr),
      .mem_wdata(mem_wdata), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .xfer_end(xfer_end),
      .end_whole(end_whole)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      int         kind;   // 0 cmd, 1 rx byte, 2 end, 3 read byte
      logic [7:0] val;
      string      req;
   } item_t;

   item_t ev_q[$];
   item_t rd_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pattern(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   // driver side: expectations
   task automatic expect_ev(input int kind, input logic [7:0] val, input string req);
      item_t it;
      it.kind = kind; it.val = val; it.req = req;
      ev_q.push_back(it);
   endtask

   task automatic expect_rd(input logic [7:0] val, input string req);
      item_t it;
      it.kind = 3; it.val = val; it.req = req;
      rd_q.push_back(it);
   endtask

   // monitor: bytes read out on sdo, sampled at rising serial clock
   int         mon_bits = 0;
   logic [7:0] mon_acc  = '0;
   always @(posedge sck or posedge sel_n) begin
      if (sel_n) begin
         mon_bits = 0;
      end else if (sdo_oe) begin
         mon_acc = {mon_acc[6:0], sdo};
         mon_bits++;
         if (mon_bits == 8) begin
            mon_bits = 0;
            if (rd_q.size() == 0) begin
               check(0, "R4", "unexpected read byte", mon_acc, 0);
            end else begin
               item_t it;
               it = rd_q.pop_front();
               check(mon_acc == it.val, it.req, "read byte", mon_acc, it.val);
            end
         end
      end
   end

   // monitor: decoded events to the controller
   task automatic take_ev(input int kind, input logic [7:0] val);
      if (ev_q.size() == 0) begin
         check(0, "R1", $sformatf("unexpected event kind %0d", kind), val, 0);
      end else begin
         item_t it;
         it = ev_q.pop_front();
         check(it.kind == kind, it.req, "event kind", kind, it.kind);
         check(it.val == val, it.req, "event value", val, it.val);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid) take_ev(0, {6'b0, cmd_kind});
         if (rx_valid)  take_ev(1, rx_byte);
         if (xfer_end)  take_ev(2, {7'b0, end_whole});
      end
   end

   // serial host tasks
   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel_begin();
      wait_clk(1);
      sel_n = 1'b0;
      wait_clk(8);
   endtask

   task automatic sel_end();
      wait_clk(8);
      sel_n = 1'b1;
      wait_clk(16);
   endtask

   task automatic xfer_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sdi = b[i];
         wait_clk(8);
         sck = 1'b1;
         wait_clk(8);
         sck = 1'b0;
      end
   endtask

   task automatic xfer_byte(input logic [7:0] b);
      xfer_bits(b, 8);
   endtask

   task automatic read_array(input int addr, input int n, input string req);
      for (int k = 0; k < n; k++) expect_rd(pattern((addr + k) & 255), req);
      expect_ev(2, 8'd1, "R9");
      sel_begin();
      xfer_byte(8'h03);
      xfer_byte(8'(addr));
      for (int k = 0; k < n; k++) xfer_byte(8'h00);
      sel_end();
   endtask

   task automatic read_status(input logic [1:0] bp, input logic wel, input logic wip);
      prot_bits = bp; wr_latch = wel; wr_busy = wip;
      expect_rd({4'hF, bp, wel, wip}, "R6");
      expect_ev(2, 8'd1, "R9");
      sel_begin();
      xfer_byte(8'h05);
      xfer_byte(8'h00);
      wait_clk(2);
      check(sdo_oe == 1'b0, "R7", "oe after status byte", sdo_oe, 0);
      xfer_byte(8'hFF);     // ignored: no event, no output
      check(sdo_oe == 1'b0, "R7", "oe during wait state", sdo_oe, 0);
      sel_end();
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      // R11: reset state
      check(sdo_oe == 1'b0, "R11", "oe in reset", sdo_oe, 0);
      check(cmd_valid == 1'b0 && rx_valid == 1'b0 && xfer_end == 1'b0,
            "R11", "pulses in reset", {cmd_valid, rx_valid, xfer_end}, 0);
      rst_n = 1'b1;
      wait_clk(4);
      check(sdo_oe == 1'b0, "R11", "oe after reset", sdo_oe, 0);

      // fill the array through the controller port
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         mem_we = 1'b1; mem_waddr = 8'(i); mem_wdata = pattern(i);
      end
      @(negedge clk) mem_we = 1'b0;

      // R4: single byte, then R5: streaming and wrap
      read_array(8'h10, 1, "R4");
      read_array(8'h10, 3, "R5");
      read_array(8'hFE, 4, "R5");

      // R6 / R7: status during a busy write and when idle
      read_status(2'b10, 1'b1, 1'b1);
      read_status(2'b01, 1'b0, 1'b0);

      // R1: write-enable set and clear; trailing byte ignored
      expect_ev(0, 8'd0, "R1");
      expect_ev(2, 8'd1, "R9");
      sel_begin(); xfer_byte(8'h06); xfer_byte(8'h3C); sel_end();
      expect_ev(0, 8'd1, "R1");
      expect_ev(2, 8'd1, "R9");
      sel_begin(); xfer_byte(8'h04); sel_end();

      // R10 / R2: status write and array write pass their bytes, MSB first
      expect_ev(0, 8'd2, "R1");
      expect_ev(1, 8'h0C, "R2");
      expect_ev(2, 8'd1, "R9");
      sel_begin(); xfer_byte(8'h01); xfer_byte(8'h0C);
      check(sdo_oe == 1'b0, "R10", "oe during write bytes", sdo_oe, 0);
      sel_end();
      expect_ev(0, 8'd3, "R1");
      expect_ev(1, 8'h40, "R10");
      expect_ev(1, 8'h5A, "R10");
      expect_ev(2, 8'd1, "R9");
      sel_begin(); xfer_byte(8'h02); xfer_byte(8'h40); xfer_byte(8'h5A); sel_end();

      // R8: unknown opcode, then a byte that would be a read opcode
      expect_ev(2, 8'd1, "R9");
      sel_begin(); xfer_byte(8'hA5); xfer_byte(8'h03);
      check(sdo_oe == 1'b0, "R8", "oe after unknown opcode", sdo_oe, 0);
      sel_end();

      // R9: abort a read mid byte, then start over cleanly
      expect_ev(2, 8'd0, "R9");
      sel_begin(); xfer_byte(8'h03); xfer_byte(8'h20); xfer_bits(8'h00, 3);
      check(sdo_oe == 1'b1, "R9", "oe during read before abort", sdo_oe, 1);
      sel_end();
      check(sdo_oe == 1'b0, "R9", "oe after abort", sdo_oe, 0);
      read_array(8'h20, 1, "R9");

      wait_clk(20);
      check(rd_q.size() == 0, "R4", "read bytes outstanding", rd_q.size(), 0);
      check(ev_q.size() == 0, "R1", "events outstanding", ev_q.size(), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule